// File: doc/BRIEF.md
# Address-Modifier Function Window Decoder

This block decides, for every access seen on a backplane bus, whether the access falls into one of the module's function windows. It holds `NUM_FN` parallel function decoders. Each decoder masks the incoming address with its own mask word and compares the result with the address field of its compare word under the same mask. It also checks the access's 6-bit address-modifier code. A separate decoder is used for each address width or transfer type the module accepts. For example, 24-bit and 32-bit addressing, or single and block transfers, each take their own decoder.

The modifier check is picked at build time by a parameter. In exact mode (`EXACT_AM = 1`, the default), the incoming modifier must equal the modifier field held in the compare word. In capability mode (`EXACT_AM = 0`), the decoder accepts any modifier whose bit is set in that decoder's 64-bit capability bitmap. A global module-enable input gates every decoder. When several decoders match, the lowest-numbered one is reported. The result is registered once: a hit flag, the winning decoder's number, and the local offset. The local offset is the incoming address with the compared bits cleared.

Top module: `amod_window_decoder`

## Requirements
- R1: Each result reflects the inputs present at one rising clock edge and is visible on the outputs right after that same edge, with no further delay.
- R2: Decoder f matches the address only when `(addr_i XOR cmp address field) AND mask` is zero. Address bits where the mask is 0 have no effect on the result.
- R3: Compare word f occupies `cmp_i[f*(ADDR_W+6) +: ADDR_W+6]`. Its low 6 bits are the modifier code and its upper `ADDR_W` bits are the address field. In exact mode a match also needs `amod_i` equal to that modifier code.
- R4: In capability mode, decoder f accepts `amod_i` exactly when bit `amod_i` of `capmap_i[f*64 +: 64]` is 1. The modifier field of the compare word is ignored.
- R5: While `mod_en_i` is 0, no decoder hits and `hit_o` is 0 after the edge.
- R6: A decoder whose mask word (`mask_i[f*ADDR_W +: ADDR_W]`) is all zeros never hits, whatever the address and modifier.
- R7: When several decoders match, `hit_fn_o` gives the lowest-numbered one.
- R8: On a hit, `offset_o` equals `addr_i AND NOT mask` of the winning decoder.
- R9: On a miss, `hit_o` is 0 and `hit_fn_o` and `offset_o` keep the values of the last hit.
- R10: While `rst_ni` is low, `hit_o`, `hit_fn_o` and `offset_o` are all zero. Reset acts without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released in step with the clock |
| mod_en_i | input | 1 | Module enable; 0 blocks every decoder |
| addr_i | input | ADDR_W | Incoming bus address |
| amod_i | input | 6 | Incoming address-modifier code |
| cmp_i | input | NUM_FN*(ADDR_W+6) | Compare words, one per decoder: {address field, modifier code} |
| mask_i | input | NUM_FN*ADDR_W | Mask words, one per decoder |
| capmap_i | input | NUM_FN*64 | Capability bitmaps, one per decoder |
| hit_o | output | 1 | Registered hit flag |
| hit_fn_o | output | max(1,clog2(NUM_FN)) | Number of the winning decoder |
| offset_o | output | ADDR_W | Local offset within the winning window |

## Verification
Every output is due one rising edge after its inputs are applied, because only one register lies between inputs and outputs. The bench changes inputs on falling edges. It compares outputs on the following falling edge, where exactly one rising edge has passed. Reset is the only asynchronous path, so the reset check samples a nanosecond after `rst_ni` falls, with no edge in between. Two instances, one exact and one capability, see identical stimulus. The bench sweeps every address and every modifier code across three register setups.

// File: rtl/amwd_pkg.sv
package amwd_pkg;
  localparam int AM_W  = 6;
  localparam int CAP_W = 1 << AM_W;

  typedef logic [AM_W-1:0] amod_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/amwd_fn_match.sv
module amwd_fn_match
  import amwd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter bit EXACT_AM = 1'b1
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  amod_t             amod_i,
  input  logic [ADDR_W-1:0] win_addr_i,
  input  amod_t             win_am_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic [CAP_W-1:0]  cap_i,
  output logic              match_o
);
  logic armed;
  logic addr_ok;
  logic am_ok;

  assign armed   = |mask_i;
  assign addr_ok = ((addr_i ^ win_addr_i) & mask_i) == '0;

  generate
    if (EXACT_AM) begin : g_exact
      logic unused_cap;
      assign unused_cap = ^cap_i;
      assign am_ok      = (amod_i == win_am_i);
    end else begin : g_capmap
      logic unused_am;
      assign unused_am = ^win_am_i;
      assign am_ok     = cap_i[amod_i];
    end
  endgenerate

  assign match_o = en_i & armed & addr_ok & am_ok;
endmodule

// File: rtl/amwd_prio_pick.sv
module amwd_prio_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/amod_window_decoder.sv
module amod_window_decoder
  import amwd_pkg::*;
#(
  parameter int NUM_FN   = 4,
  parameter int ADDR_W   = 32,
  parameter bit EXACT_AM = 1'b1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              mod_en_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [5:0]                        amod_i,
  input  logic [NUM_FN*(ADDR_W+6)-1:0]      cmp_i,
  input  logic [NUM_FN*ADDR_W-1:0]          mask_i,
  input  logic [NUM_FN*64-1:0]              capmap_i,
  output logic                              hit_o,
  output logic [idx_width(NUM_FN)-1:0]      hit_fn_o,
  output logic [ADDR_W-1:0]                 offset_o
);
  localparam int IDX_W = idx_width(NUM_FN);
  localparam int CW    = ADDR_W + AM_W;

  logic [NUM_FN-1:0] match;
  logic              any_d;
  logic [IDX_W-1:0]  idx_d;
  logic [ADDR_W-1:0] sel_mask;
  logic [ADDR_W-1:0] off_d;
  logic              upd_en;

  logic              hit_q;
  logic [IDX_W-1:0]  fn_q;
  logic [ADDR_W-1:0] off_q;

  generate
    for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
      logic [CW-1:0] word;
      assign word = cmp_i[f*CW +: CW];

      amwd_fn_match #(
        .ADDR_W  (ADDR_W),
        .EXACT_AM(EXACT_AM)
      ) u_match (
        .en_i      (mod_en_i),
        .addr_i    (addr_i),
        .amod_i    (amod_i),
        .win_addr_i(word[CW-1:AM_W]),
        .win_am_i  (word[AM_W-1:0]),
        .mask_i    (mask_i[f*ADDR_W +: ADDR_W]),
        .cap_i     (capmap_i[f*CAP_W +: CAP_W]),
        .match_o   (match[f])
      );
    end
  endgenerate

  amwd_prio_pick #(
    .N    (NUM_FN),
    .IDX_W(IDX_W)
  ) u_pick (
    .req_i(match),
    .any_o(any_d),
    .idx_o(idx_d)
  );

  // next-state
  always_comb begin
    sel_mask = '0;
    for (int f = 0; f < NUM_FN; f++) begin
      if (idx_d == IDX_W'(f)) sel_mask = mask_i[f*ADDR_W +: ADDR_W];
    end
    off_d  = addr_i & ~sel_mask;
    upd_en = any_d;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      fn_q  <= '0;
      off_q <= '0;
    end else begin
      hit_q <= any_d;
      if (upd_en) begin
        fn_q  <= idx_d;
        off_q <= off_d;
      end
    end
  end

  assign hit_o    = hit_q;
  assign hit_fn_o = fn_q;
  assign offset_o = off_q;
endmodule

// File: rtl/amwd_chk.sv
module amwd_chk
  import amwd_pkg::*;
#(
  parameter int NUM_FN   = 4,
  parameter int ADDR_W   = 32,
  parameter bit EXACT_AM = 1'b1
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              mod_en_i,
  input logic [ADDR_W-1:0]                 addr_i,
  input logic [5:0]                        amod_i,
  input logic [NUM_FN*(ADDR_W+6)-1:0]      cmp_i,
  input logic [NUM_FN*ADDR_W-1:0]          mask_i,
  input logic [NUM_FN*64-1:0]              capmap_i,
  input logic                              hit_o,
  input logic [idx_width(NUM_FN)-1:0]      hit_fn_o,
  input logic [ADDR_W-1:0]                 offset_o
);
  localparam int CW = ADDR_W + AM_W;

  logic [ADDR_W-1:0]          addr_q;
  logic [AM_W-1:0]            amod_q;
  logic [NUM_FN*CW-1:0]       cmp_q;
  logic [NUM_FN*ADDR_W-1:0]   mask_q;
  logic [NUM_FN*CAP_W-1:0]    cap_q;

  always_ff @(posedge clk_i) begin
    addr_q <= addr_i;
    amod_q <= amod_i;
    cmp_q  <= cmp_i;
    mask_q <= mask_i;
    cap_q  <= capmap_i;
  end

  int                sel;
  logic [ADDR_W-1:0] s_mask;
  logic [CW-1:0]     s_cmp;
  logic [CAP_W-1:0]  s_cap;

  always_comb begin
    sel    = (int'(hit_fn_o) < NUM_FN) ? int'(hit_fn_o) : 0;
    s_mask = mask_q[sel*ADDR_W +: ADDR_W];
    s_cmp  = cmp_q[sel*CW +: CW];
    s_cap  = cap_q[sel*CAP_W +: CAP_W];
  end

  // R5
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_en_i |=> !hit_o);

  // R6
  mask_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (s_mask != '0));

  // R2
  addr_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (((addr_q ^ s_cmp[CW-1:AM_W]) & s_mask) == '0));

  // R8
  offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (offset_o == (addr_q & ~s_mask)));

  // R9
  miss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> ($stable(hit_fn_o) && $stable(offset_o)));

  // R7
  fn_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (int'(hit_fn_o) < NUM_FN));

  generate
    if (EXACT_AM) begin : g_am_exact
      // R3
      am_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> (amod_q == s_cmp[AM_W-1:0]));
    end else begin : g_am_cap
      // R4
      am_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> s_cap[amod_q]);
    end
  endgenerate
endmodule

bind amod_window_decoder amwd_chk #(
  .NUM_FN  (NUM_FN),
  .ADDR_W  (ADDR_W),
  .EXACT_AM(EXACT_AM)
) chk_i (.*);

// File: tb/amod_window_decoder_tb_top.sv
`timescale 1ns/1ps
module amod_window_decoder_tb_top;
  localparam int NF = 3;
  localparam int AW = 8;
  localparam int CW = AW + 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              en;
  logic [AW-1:0]     addr;
  logic [5:0]        amod;
  logic [NF*CW-1:0]  cmp_v;
  logic [NF*AW-1:0]  mask_v;
  logic [NF*64-1:0]  cap_v;

  logic              he, hc;
  logic [1:0]        fe, fc;
  logic [AW-1:0]     oe, oc;

  amod_window_decoder #(.NUM_FN(NF), .ADDR_W(AW), .EXACT_AM(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mod_en_i(en), .addr_i(addr), .amod_i(amod),
    .cmp_i(cmp_v), .mask_i(mask_v), .capmap_i(cap_v),
    .hit_o(he), .hit_fn_o(fe), .offset_o(oe));

  amod_window_decoder #(.NUM_FN(NF), .ADDR_W(AW), .EXACT_AM(1'b0)) dut_cap_i (
    .clk_i(clk), .rst_ni(rst_n), .mod_en_i(en), .addr_i(addr), .amod_i(amod),
    .cmp_i(cmp_v), .mask_i(mask_v), .capmap_i(cap_v),
    .hit_o(hc), .hit_fn_o(fc), .offset_o(oc));

  int n_run = 0;
  int n_fail = 0;

  logic [AW-1:0] ca [NF];
  logic [AW-1:0] msk[NF];
  logic [5:0]    cm [NF];
  logic [63:0]   cap[NF];

  logic [1:0]    hold_fe, hold_fc;
  logic [AW-1:0] hold_oe, hold_oc;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic pack();
    for (int f = 0; f < NF; f++) begin
      cmp_v[f*CW +: CW] = {ca[f], cm[f]};
      mask_v[f*AW +: AW] = msk[f];
      cap_v[f*64 +: 64]  = cap[f];
    end
  endtask

  // expected result from the requirements: lowest matching index wins
  task automatic model(input bit capm, output bit h, output logic [1:0] idx,
                       output logic [AW-1:0] off);
    h = 1'b0; idx = '0; off = '0;
    for (int f = NF - 1; f >= 0; f--) begin
      if (en && msk[f] != '0 && ((addr ^ ca[f]) & msk[f]) == '0 &&
          (capm ? cap[f][amod] : (amod == cm[f]))) begin
        h = 1'b1; idx = 2'(f); off = addr & ~msk[f];
      end
    end
  endtask

  task automatic judge(input bit capm, input logic gh, input logic [1:0] gf,
                       input logic [AW-1:0] go, inout logic [1:0] hf,
                       inout logic [AW-1:0] ho);
    bit            h;
    logic [1:0]    idx;
    logic [AW-1:0] off;
    model(capm, h, idx, off);
    if (h) begin
      chk(capm ? "R1 R2 R4 hit" : "R1 R2 R3 hit", {31'b0, gh}, 32'd1);
      chk("R7 winner", {30'b0, gf}, {30'b0, idx});
      chk("R8 offset", {24'b0, go}, {24'b0, off});
      hf = idx; ho = off;
    end else begin
      chk(!en ? "R5 enable" : "R6 R2 miss", {31'b0, gh}, 32'd0);
      chk("R9 hold fn", {30'b0, gf}, {30'b0, hf});
      chk("R9 hold offset", {24'b0, go}, {24'b0, ho});
    end
  endtask

  task automatic setup(input int cfg);
    if (cfg == 1) begin
      ca[0] = 8'h80; msk[0] = 8'h80; cm[0] = 6'h3D; cap[0] = 64'h1 << 6'h3D;
      ca[1] = 8'h80; msk[1] = 8'hC0; cm[1] = 6'h3D; cap[1] = (64'h1 << 6'h3D) | (64'h1 << 6'h3F);
      ca[2] = 8'h85; msk[2] = 8'hFF; cm[2] = 6'h3F; cap[2] = (64'h1 << 6'h3F) | (64'h1 << 6'h0F);
      en = 1'b1;
    end else begin
      ca[0] = 8'h30; msk[0] = 8'hF0; cm[0] = 6'h39; cap[0] = (64'h1 << 6'h39) | (64'h1 << 6'h3D);
      ca[1] = 8'h00; msk[1] = 8'hC0; cm[1] = 6'h0D; cap[1] = 64'h1 << 6'h09;
      ca[2] = 8'h00; msk[2] = 8'h00; cm[2] = 6'h39; cap[2] = '1;
      en = (cfg == 0);
    end
    pack();
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; addr = 8'h35; amod = 6'h39;
    setup(0);
    repeat (3) @(negedge clk);
    // R10: matching inputs under reset leave outputs at zero
    chk("R10 reset hit", {31'b0, he}, 32'd0);
    chk("R10 reset fn", {30'b0, fc}, 32'd0);
    chk("R10 reset offset", {24'b0, oe}, 32'd0);
    hold_fe = '0; hold_fc = '0; hold_oe = '0; hold_oc = '0;
    rst_n = 1'b1;
    for (int cfg = 0; cfg < 3; cfg++) begin
      setup(cfg);
      for (int a = 0; a < 256; a++) begin
        for (int m = 0; m < 64; m++) begin
          addr = 8'(a); amod = 6'(m);
          @(negedge clk);  // R1: one rising edge has passed
          judge(1'b0, he, fe, oe, hold_fe, hold_oe);
          judge(1'b1, hc, fc, oc, hold_fc, hold_oc);
        end
      end
    end
    // R10: asynchronous reset after a hit
    setup(0); addr = 8'h3A; amod = 6'h39;
    @(negedge clk);
    chk("R3 pre-reset hit", {31'b0, he}, 32'd1);
    #1 rst_n = 1'b0;
    #1;
    chk("R10 async hit", {31'b0, he}, 32'd0);
    chk("R10 async offset", {24'b0, oe}, 32'd0);
    chk("R10 async fn", {30'b0, fc}, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule